// File: doc/BRIEF.md
# Flash Command Byte Queue with Register Readback

This block buffers the command bytes that software prepares for a flash-controller sequencer. Software loads it through a 64-bit command register. Each write carries exactly eight bytes. Short sequences are padded with idle bytes before they are written. The sequencer drains the queue one byte at a time through a valid/pop handshake. Software sees how many bytes are still unfilled, and sticky flags record when the queue filled up, drained, or had to refuse a write.

The usable capacity depends on a boot-mode input. A raised boot-disable input also empties the queue once, on its rising edge. A flush pulse empties the queue at any time. A byte the sequencer has already taken is not recalled by a flush.

For debug, software can ask the block to replay its contents into the same command register, eight bytes at a time, without consuming them. Each copied word raises a valid bit, and a read of the register clears it. A done bit marks the last copy. Byte fetch by the sequencer is held off for the whole replay.

Top module: `flcmd_queue`

## Requirements
- R1: After reset the queue is empty, `free_bytes` is 256, `exec_valid` is 0, and `flag_empty`, `flag_full`, `flag_ovf`, `rb_busy`, `rb_valid` and `rb_done` are all 0.
- R2: An accepted write appends its eight bytes with bits [7:0] first and bits [63:56] last. The sequencer receives all bytes in write order, one byte per cycle in which `exec_valid` and `exec_pop` are both high.
- R3: `free_bytes` equals the capacity minus the stored byte count. The capacity is 256 while `boot_dis` is low and 1536 while it is high; a change of `boot_dis` takes effect at the next clock edge.
- R4: `flag_full` is set when an accepted write leaves fewer than 8 free bytes. `flag_empty` is set when the sequencer takes the last stored byte in a cycle with no accepted write.
- R5: A write that finds fewer than 8 free bytes is dropped, sets `flag_ovf`, and leaves the contents and `free_bytes` unchanged.
- R6: A rising edge of `boot_dis` or a `flush` pulse empties the queue on the next edge. A write in the same cycle as the flush is discarded and does not set `flag_ovf`.
- R7: A `rb_start` pulse while no replay runs starts a replay. The replay copies, one word per handshake, every stored word from the word holding the next byte to fetch up to the last written word. It copies into `cmd_rdata` and raises `rb_valid`. `cmd_rd` clears `rb_valid`, and the next copy follows one cycle later. `rb_done` is set together with the last copy, or one cycle after the start if the queue is empty, and `rb_busy` falls at that time.
- R8: While `rb_busy` is high, `exec_valid` is low. When the replay ends, fetch resumes at the same byte where it stopped.
- R9: Any `cmd_wr` ends a running replay: `rb_busy` falls and no further word is copied.
- R10: The sticky flags are cleared by `flag_clr` (bit 0 empty, bit 1 full, bit 2 overflow), and `rb_done` by `done_clr`. A flag that is set and cleared in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Software write of the command register |
| cmd_wdata | input | 64 | Eight command bytes, lowest byte first in queue order |
| cmd_rd | input | 1 | Software read of the command register (clears `rb_valid`) |
| cmd_rdata | output | 64 | Last word copied by a replay |
| boot_dis | input | 1 | Boot finished: selects large capacity; rising edge empties queue |
| flush | input | 1 | Pulse: empty the queue |
| rb_start | input | 1 | Pulse: request a replay of the queue |
| rb_busy | output | 1 | Replay request active |
| rb_valid | output | 1 | A new word sits in `cmd_rdata` |
| rb_done | output | 1 | Sticky: replay finished |
| done_clr | input | 1 | Clear `rb_done` |
| exec_valid | output | 1 | A byte is available to the sequencer |
| exec_byte | output | 8 | Next byte for the sequencer |
| exec_pop | input | 1 | Sequencer takes the byte |
| free_bytes | output | 11 | Unfilled capacity in bytes |
| flag_empty | output | 1 | Sticky: queue drained by the sequencer |
| flag_full | output | 1 | Sticky: a write left no room for another |
| flag_ovf | output | 1 | Sticky: a write was dropped |
| flag_clr | input | 3 | Flag clears: bit 0 empty, bit 1 full, bit 2 overflow |

## Verification
A wrong fill count or pointer shows at the ports right away. A bad fill count moves `free_bytes` on the next edge, and a consume pointer that slipped by one byte gives a wrong `exec_byte` at the very next fetch. A replay that starts at the wrong word, copies one word too few, or lets the consume pointer move is caught at the first mismatched `cmd_rdata`. It is also caught at the first byte fetched after `rb_done`. Capacity and flush faults appear as a wrong `free_bytes` one cycle after the `boot_dis` edge or the flush pulse. The dropped-write path is exposed when the queue is drained and the refused word is absent.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;
  localparam int unsigned BYTE_W = 8;

  // Sticky status flags; packed order matches the flag_clr bits.
  typedef struct packed {
    logic ovf;
    logic full;
    logic empty;
  } flags_t;
endpackage

// File: rtl/flcmd_store.sv
// Word-wide queue storage: one write port, two asynchronous read ports.
module flcmd_store #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned DEPTH  = 192,
  parameter int unsigned AW     = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  output logic [WORD_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [WORD_W-1:0] rdata_b
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/flcmd_ctrl.sv
// Pointers, fill count, capacity selection, flush and sticky flags.
module flcmd_ctrl import flcmd_pkg::*; #(
  parameter int unsigned BOOT_BYTES = 256,
  parameter int unsigned FULL_BYTES = 1536,
  parameter int unsigned WORD_BYTES = 8,
  parameter int unsigned AW = 8,
  parameter int unsigned PW = 11,
  parameter int unsigned CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic          boot_dis,
  input  logic          flush_req,
  input  logic          freeze,
  input  logic          exec_pop,
  input  logic [2:0]    flag_clr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [PW-1:0] rd_pos,
  output logic [CW-1:0] fill,
  output logic [CW-1:0] free_bytes,
  output logic          exec_valid,
  output flags_t        flags,
  output logic          flush_any
);
  localparam int unsigned DEPTH = FULL_BYTES / WORD_BYTES;
  localparam logic [CW-1:0] WB_C      = CW'(WORD_BYTES);
  localparam logic [CW-1:0] CAP_BOOT  = CW'(BOOT_BYTES);
  localparam logic [CW-1:0] CAP_FULL  = CW'(FULL_BYTES);
  localparam logic [AW-1:0] LAST_W    = AW'(DEPTH - 1);
  localparam logic [PW-1:0] LAST_B    = PW'(FULL_BYTES - 1);

  logic          bd_q;
  logic [AW-1:0] wr_w;
  logic [CW-1:0] cap;
  logic [CW-1:0] fill_nxt;
  logic          accept, pop_do;
  logic          set_empty, set_full, set_ovf;

  assign cap        = bd_q ? CAP_FULL : CAP_BOOT;
  assign free_bytes = (fill >= cap) ? '0 : cap - fill;
  assign flush_any  = flush_req | (boot_dis & ~bd_q);
  assign accept     = cmd_wr & ~flush_any & (free_bytes >= WB_C);
  assign exec_valid = (fill != '0) & ~freeze;
  assign pop_do     = exec_pop & exec_valid;
  assign fill_nxt   = fill + (accept ? WB_C : '0) - (pop_do ? CW'(1) : '0);

  assign set_empty = pop_do & (fill == CW'(1)) & ~accept;
  assign set_full  = accept & ((cap - fill_nxt) < WB_C);
  assign set_ovf   = cmd_wr & ~flush_any & ~accept;

  assign mem_we    = accept;
  assign mem_waddr = wr_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      bd_q   <= 1'b0;
      wr_w   <= '0;
      rd_pos <= '0;
      fill   <= '0;
      flags  <= '0;
    end else begin
      bd_q <= boot_dis;
      if (flush_any) begin
        wr_w   <= '0;
        rd_pos <= '0;
        fill   <= '0;
      end else begin
        if (accept) wr_w <= (wr_w == LAST_W) ? '0 : wr_w + 1'b1;
        if (pop_do) rd_pos <= (rd_pos == LAST_B) ? '0 : rd_pos + 1'b1;
        fill <= fill_nxt;
      end
      flags.empty <= set_empty | (flags.empty & ~flag_clr[0]);
      flags.full  <= set_full  | (flags.full  & ~flag_clr[1]);
      flags.ovf   <= set_ovf   | (flags.ovf   & ~flag_clr[2]);
    end
  end

  // R5: a refused write must not grow the stored byte count
  a_r5_drop_keeps_fill: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !flush_any && free_bytes < WB_C) |=> (fill <= $past(fill)));

  // R6: a flush leaves nothing stored
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush_any |=> (fill == '0));

  // R4: full only ever rises after a write
  a_r4_full_after_write: assert property (@(posedge clk) disable iff (rst)
    $rose(flags.full) |-> $past(cmd_wr));

  // R3: stored bytes never exceed the large capacity
  always_comb begin
    if (!rst) a_r3_fill_in_range: assert (fill <= CAP_FULL);
  end
endmodule

// File: rtl/flcmd_rdback.sv
// Paced, non-destructive replay of stored words into the command register.
module flcmd_rdback #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned DEPTH  = 192,
  parameter int unsigned AW     = 8,
  parameter int unsigned CW     = 11,
  parameter int unsigned OW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rb_start,
  input  logic              abort,
  input  logic              cmd_rd,
  input  logic              done_clr,
  input  logic [AW-1:0]     start_word,
  input  logic [OW-1:0]     start_off,
  input  logic [CW-1:0]     fill,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [AW-1:0]     rb_addr,
  output logic              rb_busy,
  output logic              rb_valid,
  output logic              rb_done,
  output logic [WORD_W-1:0] rdata
);
  localparam logic [AW-1:0] LAST_W = AW'(DEPTH - 1);

  logic [AW:0]   rb_left;
  logic [CW:0]   span;
  logic [AW:0]   words;
  logic          step, copy, finish;

  // Bytes from the start of the current word to the write point are a
  // whole number of words because writes are word aligned.
  assign span   = {1'b0, fill} + (CW + 1)'(start_off);
  assign words  = (AW + 1)'(span >> OW);
  assign step   = rb_busy & ~abort & ~rb_valid;
  assign copy   = step & (rb_left != '0);
  assign finish = step & (rb_left <= (AW + 1)'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_busy  <= 1'b0;
      rb_addr  <= '0;
      rb_left  <= '0;
      rb_valid <= 1'b0;
      rb_done  <= 1'b0;
      rdata    <= '0;
    end else begin
      if (abort) begin
        rb_busy <= 1'b0;
      end else if (rb_start && !rb_busy) begin
        rb_busy <= 1'b1;
        rb_addr <= start_word;
        rb_left <= words;
      end else if (finish) begin
        rb_busy <= 1'b0;
      end
      if (copy) begin
        rdata   <= mem_rdata;
        rb_addr <= (rb_addr == LAST_W) ? '0 : rb_addr + 1'b1;
        rb_left <= rb_left - 1'b1;
      end
      rb_valid <= copy | (rb_valid & ~cmd_rd);
      rb_done  <= finish | (rb_done & ~done_clr);
    end
  end

  // R7: a word only appears while a replay is requested
  a_r7_valid_needs_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(rb_valid) |-> $past(rb_busy));

  // R7: completion drops the request
  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(rb_done) |-> !rb_busy);

  // R9: an abort ends the replay on the next edge
  a_r9_abort_stops: assert property (@(posedge clk) disable iff (rst)
    abort |=> !rb_busy);
endmodule

// File: rtl/flcmd_queue.sv
module flcmd_queue import flcmd_pkg::*; #(
  parameter int unsigned BOOT_BYTES = 256,
  parameter int unsigned FULL_BYTES = 1536,
  parameter int unsigned WORD_BYTES = 8,
  localparam int unsigned WORD_W = WORD_BYTES * BYTE_W,
  localparam int unsigned DEPTH  = FULL_BYTES / WORD_BYTES,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned PW     = $clog2(FULL_BYTES),
  localparam int unsigned CW     = $clog2(FULL_BYTES + 1),
  localparam int unsigned OW     = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic              cmd_rd,
  output logic [WORD_W-1:0] cmd_rdata,
  input  logic              boot_dis,
  input  logic              flush,
  input  logic              rb_start,
  output logic              rb_busy,
  output logic              rb_valid,
  output logic              rb_done,
  input  logic              done_clr,
  output logic              exec_valid,
  output logic [BYTE_W-1:0] exec_byte,
  input  logic              exec_pop,
  output logic [CW-1:0]     free_bytes,
  output logic              flag_empty,
  output logic              flag_full,
  output logic              flag_ovf,
  input  logic [2:0]        flag_clr
);
  logic              mem_we;
  logic [AW-1:0]     mem_waddr;
  logic [PW-1:0]     rd_pos;
  logic [CW-1:0]     fill;
  flags_t            flags;
  logic              flush_any;
  logic [AW-1:0]     rb_addr;
  logic [AW-1:0]     fetch_word;
  logic [OW-1:0]     fetch_off;
  logic [WORD_W-1:0] word_a, word_b;

  assign fetch_word = AW'(rd_pos >> OW);
  assign fetch_off  = rd_pos[OW-1:0];
  assign exec_byte  = word_a[fetch_off*BYTE_W +: BYTE_W];
  assign flag_empty = flags.empty;
  assign flag_full  = flags.full;
  assign flag_ovf   = flags.ovf;

  flcmd_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(cmd_wdata),
    .raddr_a(fetch_word), .rdata_a(word_a),
    .raddr_b(rb_addr), .rdata_b(word_b)
  );

  flcmd_ctrl #(
    .BOOT_BYTES(BOOT_BYTES), .FULL_BYTES(FULL_BYTES), .WORD_BYTES(WORD_BYTES),
    .AW(AW), .PW(PW), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .boot_dis(boot_dis),
    .flush_req(flush), .freeze(rb_busy), .exec_pop(exec_pop),
    .flag_clr(flag_clr), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .rd_pos(rd_pos), .fill(fill), .free_bytes(free_bytes),
    .exec_valid(exec_valid), .flags(flags), .flush_any(flush_any)
  );

  flcmd_rdback #(
    .WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW), .CW(CW), .OW(OW)
  ) u_rdback (
    .clk(clk), .rst(rst), .rb_start(rb_start), .abort(flush_any | cmd_wr),
    .cmd_rd(cmd_rd), .done_clr(done_clr), .start_word(fetch_word),
    .start_off(fetch_off), .fill(fill), .mem_rdata(word_b),
    .rb_addr(rb_addr), .rb_busy(rb_busy), .rb_valid(rb_valid),
    .rb_done(rb_done), .rdata(cmd_rdata)
  );

  // R8: the consume position holds still for the whole replay
  a_r8_fetch_frozen: assert property (@(posedge clk) disable iff (rst)
    (rb_busy && !flush_any) |=> $stable(rd_pos));
endmodule

// File: tb/sim_flcmd_queue.sv
module sim_flcmd_queue;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0, cmd_rd = 1'b0, boot_dis = 1'b0, flush = 1'b0;
  logic        rb_start = 1'b0, done_clr = 1'b0, exec_pop = 1'b0;
  logic [63:0] cmd_wdata = '0;
  logic [2:0]  flag_clr = '0;
  logic [63:0] cmd_rdata;
  logic        rb_busy, rb_valid, rb_done, exec_valid;
  logic [7:0]  exec_byte;
  logic [10:0] free_bytes;
  logic        flag_empty, flag_full, flag_ovf;

  int checks = 0, failures = 0;
  int cap_m = 256;
  logic [7:0]  exp_q[$];
  logic [63:0] wlist[3];

  always #4 clk = ~clk;

  flcmd_queue u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compare each fetched byte against the scoreboard (R2)
  always @(negedge clk) begin
    #2;
    if (!rst && exec_pop && exec_valid) begin
      if (exp_q.size() == 0) chk("R2 unexpected byte", {56'd0, exec_byte}, 64'hx);
      else chk("R2 byte order", {56'd0, exec_byte}, {56'd0, exp_q.pop_front()});
    end
  end

  task automatic wr_word(input logic [63:0] w);
    bit acc;
    acc = (cap_m - exp_q.size()) >= 8;
    if (acc) for (int i = 0; i < 8; i++) exp_q.push_back(w[i*8 +: 8]);
    cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic pop_bytes(input int n);
    exec_pop = 1'b1;
    repeat (n) @(negedge clk);
    exec_pop = 1'b0;
  endtask

  task automatic pulse_clr(input logic [2:0] m, input logic d);
    flag_clr = m; done_clr = d;
    @(negedge clk);
    flag_clr = '0; done_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 free", {53'd0, free_bytes}, 64'd256);
    chk("R1 exec_valid", {63'd0, exec_valid}, 0);
    chk("R1 flags", {61'd0, flag_ovf, flag_full, flag_empty}, 0);
    chk("R1 replay", {61'd0, rb_busy, rb_valid, rb_done}, 0);

    // R2/R3 single word then drain
    wr_word(64'h8877_6655_4433_2211);
    chk("R3 free after write", {53'd0, free_bytes}, 64'd248);
    chk("R2 first byte", {56'd0, exec_byte}, 64'h11);
    pop_bytes(8);
    chk("R4 empty set", {63'd0, flag_empty}, 1);
    chk("R3 free after drain", {53'd0, free_bytes}, 64'd256);
    pulse_clr(3'b001, 1'b0);
    chk("R10 empty cleared", {63'd0, flag_empty}, 0);

    // R4/R5 fill boot capacity, then overflow
    for (int i = 0; i < 32; i++) wr_word({32'hA5A5_0000 + i, 32'h0102_0304 * (i + 1)});
    chk("R4 full set", {63'd0, flag_full}, 1);
    chk("R3 free at boot capacity", {53'd0, free_bytes}, 0);
    chk("R5 ovf clear before", {63'd0, flag_ovf}, 0);
    wr_word(64'hDEAD_BEEF_DEAD_BEEF);
    chk("R5 ovf set", {63'd0, flag_ovf}, 1);
    chk("R5 free unchanged", {53'd0, free_bytes}, 0);
    pop_bytes(256);
    chk("R5 dropped word absent", {63'd0, exec_valid}, 0);
    chk("R5 scoreboard drained", exp_q.size(), 0);
    pulse_clr(3'b111, 1'b0);
    chk("R10 all flags cleared", {61'd0, flag_ovf, flag_full, flag_empty}, 0);

    // R6 boot_dis rising edge empties, R3 larger capacity
    wr_word(64'h1111_1111_1111_1111);
    wr_word(64'h2222_2222_2222_2222);
    boot_dis = 1'b1;
    @(negedge clk);
    exp_q.delete();
    cap_m = 1536;
    chk("R6 boot_dis empties", {63'd0, exec_valid}, 0);
    chk("R3 free large capacity", {53'd0, free_bytes}, 64'd1536);
    for (int i = 0; i < 192; i++) wr_word({16'h5A00 + 16'(i), 16'(i * 7), 32'hC0DE_0000 + i});
    chk("R4 full at large capacity", {63'd0, flag_full}, 1);
    chk("R3 free zero large", {53'd0, free_bytes}, 0);
    pop_bytes(1536);
    chk("R2 large drained", exp_q.size(), 0);
    chk("R4 empty after large", {63'd0, flag_empty}, 1);
    pulse_clr(3'b111, 1'b0);

    // R6 flush pulse wins over same-cycle write
    wr_word(64'h0F0E_0D0C_0B0A_0908);
    flush = 1'b1; cmd_wr = 1'b1; cmd_wdata = 64'h7777_7777_7777_7777;
    @(negedge clk);
    flush = 1'b0; cmd_wr = 1'b0;
    exp_q.delete();
    chk("R6 flush empties", {53'd0, free_bytes}, 64'd1536);
    chk("R6 flush no fetch", {63'd0, exec_valid}, 0);
    chk("R6 flush no ovf", {63'd0, flag_ovf}, 0);

    // R7/R8 replay from the middle of the first word
    for (int i = 0; i < 3; i++) begin
      wlist[i] = 64'h0706_0504_0302_0100 + 64'h1010_1010_1010_1010 * (i + 1);
      wr_word(wlist[i]);
    end
    pop_bytes(3);
    rb_start = 1'b1;
    @(negedge clk);
    rb_start = 1'b0;
    chk("R8 fetch frozen", {63'd0, exec_valid}, 0);
    for (int i = 0; i < 3; i++) begin
      for (int t = 0; t < 20 && !rb_valid; t++) @(negedge clk);
      chk("R7 replay word", cmd_rdata, wlist[i]);
      if (i == 2) chk("R7 done with last copy", {62'd0, rb_done, rb_busy}, 64'd2);
      else chk("R7 not done yet", {63'd0, rb_done}, 0);
      cmd_rd = 1'b1;
      @(negedge clk);
      cmd_rd = 1'b0;
      chk("R7 valid cleared by read", {63'd0, rb_valid}, 0);
    end
    chk("R8 fetch resumes", {63'd0, exec_valid}, 1);
    chk("R8 same byte", {56'd0, exec_byte}, {56'd0, wlist[0][31:24]});
    pop_bytes(21);
    pulse_clr(3'b111, 1'b1);
    chk("R10 done cleared", {63'd0, rb_done}, 0);

    // R7 replay of an empty queue
    rb_start = 1'b1;
    @(negedge clk);
    rb_start = 1'b0;
    @(negedge clk);
    chk("R7 empty replay done", {62'd0, rb_done, rb_valid}, 64'd2);
    chk("R7 empty replay idle", {63'd0, rb_busy}, 0);
    pulse_clr(3'b000, 1'b1);

    // R9 a write aborts the replay
    wr_word(64'hAAAA_0000_BBBB_1111);
    wr_word(64'hCCCC_2222_DDDD_3333);
    rb_start = 1'b1;
    @(negedge clk);
    rb_start = 1'b0;
    w = 64'hEEEE_4444_FFFF_5555;
    wr_word(w);
    chk("R9 busy cleared", {63'd0, rb_busy}, 0);
    chk("R9 no copy", {63'd0, rb_valid}, 0);
    chk("R9 fetch resumes", {63'd0, exec_valid}, 1);
    pop_bytes(24);
    chk("R9 drained", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule